// File: doc/BRIEF.md
# Serial Card Host Register Front End

This block sits between a host's narrow register bus and the serial engines of an asynchronous communication card. The host sees four register addresses: a data port, a control/status port, an extended control/status port for the modem lines, and a trigger port. A write to the trigger port hands the byte latched at the data port to the transmit engine. A read of the data port takes the byte waiting in the receive engine.

Bit 0 of the control register repurposes the data port. While it is set, a read of the data port returns the receiver-transmitter status word, and a write goes to its configuration instead. A small sequencer decides whether that write lands in the mode word or the command word. After any reset it expects the mode word first, and every later write goes to the command word. A command word with bit 6 set resets the receiver-transmitter, clears both words and re-arms the sequence. Writing bit 5 of the control register returns the whole block to its power-on state.

Top module: `sio_host_regs`

## Requirements
- R1: After `rst_n` is low at a clock edge, `tx_load`, `rx_take`, `engine_rst`, `host_rdata`, `tx_byte`, `ext_ctrl`, `mode_word` and `cmd_word` are all 0, the data port is in payload mode, and the sequencer expects the mode word.
- R2: In payload mode, a write to address 0 latches the byte onto `tx_byte` one cycle later. A write to address 3 while `tx_ready` is 1 raises `tx_load` for exactly one cycle, starting the cycle after the write. While `tx_ready` is 0, a trigger write produces no `tx_load`.
- R3: In payload mode, a read of address 0 puts `rx_byte` on `host_rdata` one cycle later. If `rx_valid` was 1, it also raises `rx_take` for one cycle.
- R4: A read of address 1 returns the status byte. Its bits 5:4 hold the parameter `TYPE_ID` and all its other bits are 0.
- R5: Writing 1 to control bit 0 (address 1) selects control mode. In control mode, a read of address 0 returns `usart_stat` and never raises `rx_take`.
- R6: The first control-mode write to address 0 after any reset goes to `mode_word`. Every later one goes to `cmd_word`, and `mode_word` keeps its value.
- R7: A command-word write with bit 6 set pulses `engine_rst` for one cycle. It returns `mode_word` and `cmd_word` to 0 and makes the next control-mode write go to `mode_word`. This repeats if that sequence again writes a command with bit 6 set.
- R8: Writing 1 to control bit 5 pulses `engine_rst`. It clears `tx_byte`, `ext_ctrl`, `mode_word`, `cmd_word` and control bit 0, so address 0 reads `rx_byte` again, and it re-arms the mode-first sequence.
- R9: A write to address 2 sets `ext_ctrl` one cycle later. A read of address 2 returns `ext_stat`.
- R10: Control-mode writes to address 0 leave `tx_byte` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 2 | Register select: 0 data, 1 control/status, 2 extended, 3 trigger |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, registered |
| tx_byte | output | 8 | Byte held for the transmit engine |
| tx_load | output | 1 | One-cycle start pulse to the transmit engine |
| tx_ready | input | 1 | Transmit engine can accept a byte |
| rx_byte | input | 8 | Byte from the receive engine |
| rx_valid | input | 1 | Receive engine holds a byte |
| rx_take | output | 1 | One-cycle pulse: host consumed the byte |
| usart_stat | input | 8 | Receiver-transmitter status word |
| mode_word | output | 8 | Configured mode word |
| cmd_word | output | 8 | Configured command word |
| engine_rst | output | 1 | One-cycle reset pulse to the serial engines |
| ext_ctrl | output | 8 | Modem-line control register |
| ext_stat | input | 8 | Modem-line status inputs |

## Verification
Every result is one register away from the host strobe that causes it. Read data, the `tx_load` and `rx_take` pulses, the `engine_rst` pulse and all configuration outputs appear in the cycle after the strobe's clock edge. The bench drives strobes on the falling edge and checks results at the next falling edge, after exactly one rising edge has passed. For each pulse it checks one falling edge later that the pulse has dropped again.

// File: rtl/sio_pkg.sv
// Shared types for the serial card host front end.
// Assumes an 8-bit host bus with a 2-bit register address.
package sio_pkg;
    typedef enum logic [1:0] {
        RA_DATA = 2'd0,
        RA_CTRL = 2'd1,
        RA_EXT  = 2'd2,
        RA_TRIG = 2'd3
    } reg_addr_e;

    typedef enum logic {
        SQ_MODE = 1'b0,
        SQ_CMD  = 1'b1
    } seq_e;

    localparam int CTRL_SEL_BIT = 0;  // data port selects config/status
    localparam int CTRL_RST_BIT = 5;  // whole-card reset
    localparam int CMD_RST_BIT  = 6;  // receiver-transmitter reset in command
    localparam int ID_LSB       = 4;  // type id position in status byte
endpackage

// File: rtl/sio_ctrl_regs.sv
// Control and extended control registers.
// Holds the port-select bit and the modem-line control byte.
// Assumes card_rst and the write strobes come from one address decode.
module sio_ctrl_regs #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          card_rst,
    input  logic          wr_ctrl,
    input  logic          sel_in,
    input  logic          wr_ext,
    input  logic [DW-1:0] ext_in,
    output logic          sel_ctl,
    output logic [DW-1:0] ext_ctrl
);
    // Port-select bit: set or cleared by control writes, cleared by any reset.
    always_ff @(posedge clk) begin
        if (!rst_n || card_rst) sel_ctl <= 1'b0;
        else if (wr_ctrl)       sel_ctl <= sel_in;
    end

    // Modem-line control byte.
    always_ff @(posedge clk) begin
        if (!rst_n || card_rst) ext_ctrl <= '0;
        else if (wr_ext)        ext_ctrl <= ext_in;
    end

    a_r8_sel_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        card_rst |=> (!sel_ctl && ext_ctrl == '0));
    a_r9_ext_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ext && !card_rst) |=> (ext_ctrl == $past(ext_in)));
endmodule

// File: rtl/sio_usart_seq.sv
// Mode/command write sequencer for the receiver-transmitter configuration.
// After any reset the first config write goes to the mode word and later
// writes go to the command word. A command with the reset bit set
// clears both words and re-arms the mode-first order.
module sio_usart_seq
    import sio_pkg::*;
#(
    parameter int          DW       = 8,
    parameter logic [DW-1:0] MODE_RST = '0,
    parameter logic [DW-1:0] CMD_RST  = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          card_rst,
    input  logic          wr_cfg,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] mode_word,
    output logic [DW-1:0] cmd_word,
    output logic          usart_rst
);
    seq_e state;

    // Command write carrying the reset bit.
    always_comb usart_rst = wr_cfg && (state == SQ_CMD) && wdata[CMD_RST_BIT];

    // Sequencer state and configuration words.
    always_ff @(posedge clk) begin
        if (!rst_n || card_rst || usart_rst) begin
            state     <= SQ_MODE;
            mode_word <= MODE_RST;
            cmd_word  <= CMD_RST;
        end else if (wr_cfg) begin
            if (state == SQ_MODE) begin
                mode_word <= wdata;
                state     <= SQ_CMD;
            end else begin
                cmd_word <= wdata;
            end
        end
    end

    a_r6_mode_first: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cfg && !card_rst && state == SQ_MODE)
        |=> (state == SQ_CMD && mode_word == $past(wdata) && $stable(cmd_word)));
    a_r6_mode_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cfg && !card_rst && state == SQ_CMD && !wdata[CMD_RST_BIT])
        |=> ($stable(mode_word) && cmd_word == $past(wdata)));
    a_r7_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        usart_rst |=> (state == SQ_MODE && mode_word == MODE_RST && cmd_word == CMD_RST));
    a_r8_card_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        card_rst |=> (state == SQ_MODE && mode_word == MODE_RST));
endmodule

// File: rtl/sio_data_path.sv
// Transmit holding byte, trigger pulse, receive take pulse and read mux.
// Read data is registered. Assumes at most one strobe decode is active.
module sio_data_path
    import sio_pkg::*;
#(
    parameter int         DW      = 8,
    parameter int         IDW     = 2,
    parameter logic [IDW-1:0] TYPE_ID = 2'b01
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          card_rst,
    input  logic          sel_ctl,
    input  logic          wr_data,
    input  logic          wr_trig,
    input  logic          rd_en,
    input  reg_addr_e     rd_addr,
    input  logic [DW-1:0] wdata,
    input  logic          tx_ready,
    input  logic [DW-1:0] rx_byte,
    input  logic          rx_valid,
    input  logic [DW-1:0] usart_stat,
    input  logic [DW-1:0] ext_stat,
    output logic [DW-1:0] tx_byte,
    output logic          tx_load,
    output logic          rx_take,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] stat_byte;
    logic [DW-1:0] rd_mux;

    // Fixed status byte: type id only, other bits zero.
    always_comb begin
        stat_byte = '0;
        stat_byte[ID_LSB +: IDW] = TYPE_ID;
    end

    // Read source selection.
    always_comb begin
        unique case (rd_addr)
            RA_DATA: rd_mux = sel_ctl ? usart_stat : rx_byte;
            RA_CTRL: rd_mux = stat_byte;
            RA_EXT:  rd_mux = ext_stat;
            default: rd_mux = '0;
        endcase
    end

    // Transmit holding byte, payload-mode writes only.
    always_ff @(posedge clk) begin
        if (!rst_n || card_rst)      tx_byte <= '0;
        else if (wr_data && !sel_ctl) tx_byte <= wdata;
    end

    // Engine handshakes and registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_load <= 1'b0;
            rx_take <= 1'b0;
            rdata   <= '0;
        end else begin
            tx_load <= wr_trig && tx_ready && !card_rst;
            rx_take <= rd_en && (rd_addr == RA_DATA) && !sel_ctl && rx_valid;
            if (rd_en) rdata <= rd_mux;
        end
    end

    a_r2_load_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |-> $past(tx_ready));
    a_r5_no_take_in_ctl: assert property (@(posedge clk) disable iff (!rst_n)
        rx_take |-> ($past(rx_valid) && !$past(sel_ctl)));
    a_r4_status_id: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == RA_CTRL) |=> (rdata[ID_LSB +: IDW] == TYPE_ID));
    a_r10_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && sel_ctl && !card_rst) |=> $stable(tx_byte));
endmodule

// File: rtl/sio_host_regs.sv
// Top of the serial card host front end.
// Decodes host strobes into register actions, generates the card reset
// and the engine reset pulse, and wires the sub-blocks.
// Assumes host_wr and host_rd are not both high in one cycle.
module sio_host_regs
    import sio_pkg::*;
#(
    parameter int         DW      = 8,
    parameter int         IDW     = 2,
    parameter logic [IDW-1:0] TYPE_ID = 2'b01
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    host_addr,
    input  logic          host_wr,
    input  logic          host_rd,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    output logic [DW-1:0] tx_byte,
    output logic          tx_load,
    input  logic          tx_ready,
    input  logic [DW-1:0] rx_byte,
    input  logic          rx_valid,
    output logic          rx_take,
    input  logic [DW-1:0] usart_stat,
    output logic [DW-1:0] mode_word,
    output logic [DW-1:0] cmd_word,
    output logic          engine_rst,
    output logic [DW-1:0] ext_ctrl,
    input  logic [DW-1:0] ext_stat
);
    reg_addr_e addr;
    logic wr_data, wr_ctrl, wr_ext, wr_trig, card_rst, wr_cfg;
    logic sel_ctl, usart_rst;

    // Host strobe decode.
    always_comb begin
        addr     = reg_addr_e'(host_addr);
        wr_data  = host_wr && (addr == RA_DATA);
        wr_ctrl  = host_wr && (addr == RA_CTRL);
        wr_ext   = host_wr && (addr == RA_EXT);
        wr_trig  = host_wr && (addr == RA_TRIG);
        card_rst = wr_ctrl && host_wdata[CTRL_RST_BIT];
        wr_cfg   = wr_data && sel_ctl;
    end

    // Engine reset pulse from card or receiver-transmitter reset.
    always_ff @(posedge clk) begin
        if (!rst_n) engine_rst <= 1'b0;
        else        engine_rst <= card_rst || usart_rst;
    end

    sio_ctrl_regs #(.DW(DW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .card_rst(card_rst),
        .wr_ctrl(wr_ctrl), .sel_in(host_wdata[CTRL_SEL_BIT]),
        .wr_ext(wr_ext), .ext_in(host_wdata),
        .sel_ctl(sel_ctl), .ext_ctrl(ext_ctrl)
    );

    sio_usart_seq #(.DW(DW), .MODE_RST('0), .CMD_RST('0)) u_seq (
        .clk(clk), .rst_n(rst_n), .card_rst(card_rst),
        .wr_cfg(wr_cfg), .wdata(host_wdata),
        .mode_word(mode_word), .cmd_word(cmd_word), .usart_rst(usart_rst)
    );

    sio_data_path #(.DW(DW), .IDW(IDW), .TYPE_ID(TYPE_ID)) u_dp (
        .clk(clk), .rst_n(rst_n), .card_rst(card_rst), .sel_ctl(sel_ctl),
        .wr_data(wr_data), .wr_trig(wr_trig), .rd_en(host_rd), .rd_addr(addr),
        .wdata(host_wdata), .tx_ready(tx_ready), .rx_byte(rx_byte),
        .rx_valid(rx_valid), .usart_stat(usart_stat), .ext_stat(ext_stat),
        .tx_byte(tx_byte), .tx_load(tx_load), .rx_take(rx_take), .rdata(host_rdata)
    );

    a_r7_engine_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        engine_rst |=> !engine_rst);
    a_r8_card_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        card_rst |=> (engine_rst && tx_byte == '0));
endmodule

// File: tb/sio_host_regs_test.sv
module sio_host_regs_test;
    localparam int CLK_NS = 10;
    localparam logic [1:0] TID = 2'b01;
    localparam logic [7:0] RXB = 8'h5A, UST = 8'hC3, EST = 8'h96;

    logic clk = 0, rst_n = 0;
    logic [1:0] host_addr = 0;
    logic host_wr = 0, host_rd = 0, tx_ready = 0, rx_valid = 0;
    logic [7:0] host_wdata = 0, rx_byte = RXB, usart_stat = UST, ext_stat = EST;
    logic [7:0] host_rdata, tx_byte, mode_word, cmd_word, ext_ctrl;
    logic tx_load, rx_take, engine_rst;
    int n_chk = 0, n_bad = 0, cyc = 0;

    always #(CLK_NS/2) clk = ~clk;

    sio_host_regs #(.TYPE_ID(TID)) uut (.*);

    // Vector: {is_read, addr[1:0], data/expected[7:0], req[3:0]}
    localparam int NV = 9;
    localparam logic [14:0] VEC [NV] = '{
        {1'b1, 2'd1, 8'h10, 4'd4},   // R4 status byte
        {1'b1, 2'd0, RXB,   4'd3},   // R3 payload read
        {1'b0, 2'd2, 8'h3C, 4'd9},   // R9 ext write
        {1'b1, 2'd2, EST,   4'd9},   // R9 ext read
        {1'b0, 2'd1, 8'h01, 4'd5},   // R5 enter control mode
        {1'b1, 2'd0, UST,   4'd5},   // R5 status word
        {1'b1, 2'd1, 8'h10, 4'd4},   // R4 status in control mode
        {1'b0, 2'd1, 8'h00, 4'd5},   // leave control mode
        {1'b1, 2'd0, RXB,   4'd3}    // R3 payload read again
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        host_addr = a; host_wdata = d; host_wr = 1;
        @(negedge clk);
        host_wr = 0;
    endtask

    task automatic rd(input logic [1:0] a);
        host_addr = a; host_rd = 1;
        @(negedge clk);
        host_rd = 0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=<20000", cyc);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk("R1 tx_load", {7'b0, tx_load}, 8'h00);
        chk("R1 rx_take", {7'b0, rx_take}, 8'h00);
        chk("R1 engine_rst", {7'b0, engine_rst}, 8'h00);
        chk("R1 rdata", host_rdata, 8'h00);
        chk("R1 tx_byte", tx_byte, 8'h00);
        chk("R1 mode", mode_word, 8'h00);
        chk("R1 cmd", cmd_word, 8'h00);
        chk("R1 ext", ext_ctrl, 8'h00);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", VEC[i][3:0], i);
            if (VEC[i][14]) begin
                rd(VEC[i][13:12]);
                chk(tag, host_rdata, VEC[i][11:4]);
            end else begin
                wr(VEC[i][13:12], VEC[i][11:4]);
                if (VEC[i][13:12] == 2'd2) chk(tag, ext_ctrl, VEC[i][11:4]);
            end
        end

        // R2 transmit latch and trigger
        wr(2'd0, 8'hA5);
        chk("R2 tx_byte", tx_byte, 8'hA5);
        tx_ready = 1;
        wr(2'd3, 8'h00);
        chk("R2 tx_load high", {7'b0, tx_load}, 8'h01);
        @(negedge clk);
        chk("R2 tx_load one cycle", {7'b0, tx_load}, 8'h00);
        tx_ready = 0;
        wr(2'd3, 8'h00);
        chk("R2 no load when busy", {7'b0, tx_load}, 8'h00);

        // R3 take pulse
        rx_valid = 1;
        rd(2'd0);
        chk("R3 rdata", host_rdata, RXB);
        chk("R3 rx_take", {7'b0, rx_take}, 8'h01);
        @(negedge clk);
        chk("R3 take one cycle", {7'b0, rx_take}, 8'h00);
        rx_valid = 0;
        rd(2'd0);
        chk("R3 no take when empty", {7'b0, rx_take}, 8'h00);

        // R5 control mode read: no take
        rx_valid = 1;
        wr(2'd1, 8'h01);
        rd(2'd0);
        chk("R5 status word", host_rdata, UST);
        chk("R5 no take", {7'b0, rx_take}, 8'h00);
        rx_valid = 0;

        // R6 / R10 sequencing
        wr(2'd0, 8'h4E);
        chk("R6 mode first", mode_word, 8'h4E);
        chk("R6 cmd untouched", cmd_word, 8'h00);
        chk("R10 tx_byte kept", tx_byte, 8'hA5);
        wr(2'd0, 8'h15);
        chk("R6 cmd second", cmd_word, 8'h15);
        wr(2'd0, 8'h27);
        chk("R6 cmd third", cmd_word, 8'h27);
        chk("R6 mode kept", mode_word, 8'h4E);
        chk("R10 tx_byte still", tx_byte, 8'hA5);

        // R7 command reset and re-arm
        wr(2'd0, 8'h40);
        chk("R7 engine_rst", {7'b0, engine_rst}, 8'h01);
        chk("R7 mode cleared", mode_word, 8'h00);
        chk("R7 cmd cleared", cmd_word, 8'h00);
        wr(2'd0, 8'h0B);
        chk("R7 pulse ends", {7'b0, engine_rst}, 8'h00);
        chk("R7 mode after reset", mode_word, 8'h0B);
        wr(2'd0, 8'h45);
        chk("R7 repeat reset", {7'b0, engine_rst}, 8'h01);
        chk("R7 mode discarded", mode_word, 8'h00);
        wr(2'd0, 8'h0C);
        chk("R7 mode again", mode_word, 8'h0C);
        wr(2'd0, 8'h11);
        chk("R7 cmd again", cmd_word, 8'h11);

        // R8 card reset
        wr(2'd2, 8'h77);
        wr(2'd1, 8'h21);
        chk("R8 engine_rst", {7'b0, engine_rst}, 8'h01);
        chk("R8 mode", mode_word, 8'h00);
        chk("R8 cmd", cmd_word, 8'h00);
        chk("R8 ext", ext_ctrl, 8'h00);
        chk("R8 tx_byte", tx_byte, 8'h00);
        rd(2'd0);
        chk("R8 back to payload", host_rdata, RXB);
        wr(2'd1, 8'h01);
        wr(2'd0, 8'h2A);
        chk("R8 mode first again", mode_word, 8'h2A);
        chk("R8 cmd stays", cmd_word, 8'h00);

        // R1 reset pin after activity
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        chk("R1 mode after rst", mode_word, 8'h00);
        chk("R1 rdata after rst", host_rdata, 8'h00);
        finish_run();
    end
endmodule